// File: doc/BRIEF.md
# DDR3 Power-Up Reset and Clock-Enable Sequencer

This block sits at the front of a DDR3 memory controller and handles the power-up window between releasing the DRAM reset and enabling the DRAM clock. Software loads a refresh interval and then writes the configuration register. That write starts the hardware sequence. The DRAM reset output goes high at once, and the clock enable is held low for a wait that is derived from the refresh interval, shifted left by a parameter (×16 by default). At 400 MHz an interval of 0x3100 gives 200704 cycles, which is a little over 500 µs. The clock enable then rises. One cycle later the block emits a single-cycle pulse that tells the command logic to issue the mode-register commands, and from the following cycle it reports itself ready.

A separate permit register gates the clock-enable output. While the permit is clear, the clock enable stays low whatever the sequencer has reached. Memory accesses that arrive before the block is ready receive an error response instead of stalling. Once the block is ready, software rewrites the same interval field with the normal refresh period, and the block then produces a one-cycle refresh strobe at that period.

Internally, a sequencer state machine runs through these states: IDLE (reset held low), WAIT (counting), HOLD (wait over, permit clear), CKE_UP (clock enable raised), ISSUE (command pulse) and READY. Its transitions are named below.
- IDLE→WAIT: on a configuration write.
- WAIT→CKE_UP: on expiry with the permit set.
- WAIT→HOLD: on expiry with the permit clear.
- HOLD→CKE_UP: when the permit is set.
- CKE_UP→ISSUE and ISSUE→READY: each unconditional.
- Any state→WAIT: on a configuration write.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: After reset, dram_reset_n, dram_cke, init_done, init_cmd_pulse and refresh_pulse are all 0.
- R2: Register map, with reads combinational on cfg_rdata:
  - Address 0 holds the refresh interval in bits [15:0]. The other bits read 0.
  - Address 1 holds the 32-bit configuration value.
  - Address 2 bit 0 is the clock-enable permit. Its reset value is 0.
  - Address 3 is read-only status: bit 0 is busy and bit 1 is ready (init_done).
- R3: Only a write to address 1 starts the sequence. dram_reset_n is high after that write's clock edge, and dram_cke is low.
- R4: With the permit set, dram_cke rises exactly max(I << WAIT_SHIFT, 1) cycles after the starting write edge, where I is the interval held at that edge. dram_reset_n stays high and dram_cke stays low throughout the wait.
- R5: While the permit is 0, dram_cke is 0. If the wait expires while the permit is 0, the sequencer holds. dram_cke then rises one cycle after the edge that writes the permit to 1. Clearing the permit later drops dram_cke after that write's edge.
- R6: init_cmd_pulse is high for exactly one cycle, the cycle after dram_cke rises. init_done is 1 from the next cycle and stays 1 until the next configuration write.
- R7: A configuration write during a sequence, or after one has finished, restarts the wait from zero with the interval held at that moment, and clears init_done. An interval write during the wait does not change the current wait.
- R8: Each cycle with mem_req high is answered one cycle later with mem_rsp_valid = 1. mem_rsp_err is 1 if init_done was 0 in the request cycle and 0 otherwise. mem_rsp_valid is 0 when there was no request.
- R9: refresh_pulse occurs only while init_done is 1. It is a one-cycle pulse every I cycles, with the first pulse I-1 cycles after init_done rises or after an interval write. An interval of 0 produces no pulses.
- R10: The status busy bit is 1 from the starting write until init_done rises, and it is never 1 together with init_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mem_req | input | 1 | Memory access request |
| mem_rsp_valid | output | 1 | Response valid, one cycle after a request |
| mem_rsp_err | output | 1 | Response status: 1 is error, 0 is okay |
| dram_reset_n | output | 1 | DRAM reset, active low |
| dram_cke | output | 1 | DRAM clock enable |
| init_cmd_pulse | output | 1 | One-cycle request to issue the initialization commands |
| init_done | output | 1 | Power-up sequence complete |
| refresh_pulse | output | 1 | Periodic refresh strobe |

## Verification
A wrong wait count or wait length shows at dram_cke, which rises early or late against the arithmetic count of interval cycles. The bench measures this to the exact cycle for intervals swept from 0 to 33 and for 0x3100. A state machine stuck in or skipping HOLD, CKE_UP or ISSUE shows within one or two cycles on dram_cke, init_cmd_pulse, init_done or the busy status bit. A wrong ready state shows on the very next memory response as a wrong error bit. A faulty refresh counter shows as a misplaced first strobe or a wrong period, within one interval.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_CKE_UP,
        ST_ISSUE,
        ST_READY
    } seq_state_e;

    localparam logic [1:0] A_INTERVAL = 2'd0;
    localparam logic [1:0] A_CONFIG   = 2'd1;
    localparam logic [1:0] A_PERMIT   = 2'd2;
    localparam logic [1:0] A_STATUS   = 2'd3;

endpackage

// File: rtl/ddr_seq_regs.sv
module ddr_seq_regs
    import ddr_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [REF_W-1:0]  interval,
    output logic              cke_permit,
    output logic              start,
    output logic              interval_wr
);

    logic [DATA_W-1:0] config_q;

    // Write strobes decoded per register
    assign start       = wr && (addr == A_CONFIG);
    assign interval_wr = wr && (addr == A_INTERVAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval   <= '0;
            config_q   <= '0;
            cke_permit <= 1'b0;
        end else if (wr) begin
            unique case (addr)
                A_INTERVAL: interval   <= wdata[REF_W-1:0];
                A_CONFIG:   config_q   <= wdata;
                A_PERMIT:   cke_permit <= wdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_INTERVAL: rdata = DATA_W'(interval);
            A_CONFIG:   rdata = config_q;
            A_PERMIT:   rdata = DATA_W'(cke_permit);
            default:    rdata = DATA_W'({done, busy});
        endcase
    end

endmodule

// File: rtl/ddr_seq_fsm.sv
module ddr_seq_fsm
    import ddr_seq_pkg::*;
#(
    parameter int REF_W      = 16,
    parameter int WAIT_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REF_W-1:0] interval,
    input  logic             cke_permit,
    output logic             reset_n_o,
    output logic             cke_o,
    output logic             init_pulse_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam int CNT_W = REF_W + WAIT_SHIFT + 1;

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] wait_cnt;
    logic [CNT_W-1:0] wait_len;
    logic             expire;
    logic             cke_want;

    // Wait is over once the next count reaches the latched length (minimum one cycle)
    assign expire = (wait_cnt + CNT_W'(1)) >= wait_len;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Wait counter; length latched from the interval at each start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            wait_len <= '0;
        end else if (start) begin
            wait_cnt <= '0;
            wait_len <= CNT_W'(interval) << WAIT_SHIFT;
        end else if (state == ST_WAIT) begin
            wait_cnt <= wait_cnt + CNT_W'(1);
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_WAIT;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_WAIT:   if (expire) nxt = cke_permit ? ST_CKE_UP : ST_HOLD;
                ST_HOLD:   if (cke_permit) nxt = ST_CKE_UP;
                ST_CKE_UP: nxt = ST_ISSUE;
                ST_ISSUE:  nxt = ST_READY;
                ST_READY:  nxt = ST_READY;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs from the state
    always_comb begin
        reset_n_o    = 1'b1;
        cke_want     = 1'b0;
        init_pulse_o = 1'b0;
        done_o       = 1'b0;
        busy_o       = 1'b0;
        unique case (state)
            ST_IDLE:   reset_n_o = 1'b0;
            ST_WAIT:   busy_o    = 1'b1;
            ST_HOLD:   busy_o    = 1'b1;
            ST_CKE_UP: begin
                busy_o   = 1'b1;
                cke_want = 1'b1;
            end
            ST_ISSUE:  begin
                busy_o       = 1'b1;
                cke_want     = 1'b1;
                init_pulse_o = 1'b1;
            end
            ST_READY:  begin
                cke_want = 1'b1;
                done_o   = 1'b1;
            end
            default:   reset_n_o = 1'b0;
        endcase
        cke_o = cke_want && cke_permit;
    end

endmodule

// File: rtl/ddr_seq_refresh.sv
module ddr_seq_refresh #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [REF_W-1:0] interval,
    output logic             strobe
);

    logic [REF_W-1:0] cnt;
    logic             off;
    logic             at_end;

    assign off    = (interval == '0);
    assign at_end = (cnt == (interval - REF_W'(1)));
    assign strobe = run && !off && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (!run || reload || off)    cnt <= '0;
        else if (at_end)                   cnt <= '0;
        else                               cnt <= cnt + REF_W'(1);
    end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq #(
    parameter int DATA_W     = 32,
    parameter int REF_W      = 16,
    parameter int WAIT_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              mem_req,
    output logic              mem_rsp_valid,
    output logic              mem_rsp_err,
    output logic              dram_reset_n,
    output logic              dram_cke,
    output logic              init_cmd_pulse,
    output logic              init_done,
    output logic              refresh_pulse
);

    logic [REF_W-1:0] interval;
    logic             cke_permit;
    logic             start;
    logic             interval_wr;
    logic             seq_busy;

    ddr_seq_regs #(.DATA_W(DATA_W), .REF_W(REF_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (cfg_wr),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .busy        (seq_busy),
        .done        (init_done),
        .rdata       (cfg_rdata),
        .interval    (interval),
        .cke_permit  (cke_permit),
        .start       (start),
        .interval_wr (interval_wr)
    );

    ddr_seq_fsm #(.REF_W(REF_W), .WAIT_SHIFT(WAIT_SHIFT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .interval     (interval),
        .cke_permit   (cke_permit),
        .reset_n_o    (dram_reset_n),
        .cke_o        (dram_cke),
        .init_pulse_o (init_cmd_pulse),
        .done_o       (init_done),
        .busy_o       (seq_busy)
    );

    ddr_seq_refresh #(.REF_W(REF_W)) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (init_done),
        .reload   (interval_wr),
        .interval (interval),
        .strobe   (refresh_pulse)
    );

    // Access response: error until the sequence has completed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
        end else begin
            mem_rsp_valid <= mem_req;
            mem_rsp_err   <= mem_req && !init_done;
        end
    end

endmodule

// File: rtl/ddr_seq_chk.sv
module ddr_seq_chk
    import ddr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [1:0] cfg_addr,
    input logic       cke_permit,
    input logic       busy,
    input logic       dram_reset_n,
    input logic       dram_cke,
    input logic       init_cmd_pulse,
    input logic       init_done,
    input logic       refresh_pulse,
    input logic       mem_req,
    input logic       mem_rsp_valid,
    input logic       mem_rsp_err
);

    p_cke_needs_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cke |-> dram_reset_n);

    p_permit_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_permit |-> !dram_cke);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == A_CONFIG) |=> (dram_reset_n && !dram_cke && !init_done && busy));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_cmd_pulse && !(cfg_wr && cfg_addr == A_CONFIG)) |=> (!init_cmd_pulse && init_done));

    p_done_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(init_cmd_pulse));

    p_refresh_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |-> init_done);

    p_rsp_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (mem_rsp_valid && (mem_rsp_err == !$past(init_done))));

    p_rsp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> $past(mem_req));

    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && init_done));

endmodule

bind ddr_pwrup_seq ddr_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_addr       (cfg_addr),
    .cke_permit     (cke_permit),
    .busy           (seq_busy),
    .dram_reset_n   (dram_reset_n),
    .dram_cke       (dram_cke),
    .init_cmd_pulse (init_cmd_pulse),
    .init_done      (init_done),
    .refresh_pulse  (refresh_pulse),
    .mem_req        (mem_req),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_err    (mem_rsp_err)
);

// File: tb/test_ddr_pwrup_seq.sv
module test_ddr_pwrup_seq;

    localparam int SH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        mem_req = 1'b0;
    logic        mem_rsp_valid, mem_rsp_err;
    logic        dram_reset_n, dram_cke, init_cmd_pulse, init_done, refresh_pulse;

    int vectors = 0;
    int errs = 0;

    always #4 clk = ~clk;

    ddr_pwrup_seq #(.DATA_W(32), .REF_W(16), .WAIT_SHIFT(SH)) i_ddr_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .dram_reset_n(dram_reset_n), .dram_cke(dram_cke),
        .init_cmd_pulse(init_cmd_pulse), .init_done(init_done),
        .refresh_pulse(refresh_pulse)
    );

    task automatic chkv(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic mem_probe(input string tag);
        logic exp_err;
        exp_err = !init_done;
        mem_req = 1'b1;
        @(negedge clk);
        mem_req = 1'b0;
        chkv({tag, " R8 valid"}, mem_rsp_valid, 1);
        chkv({tag, " R8 err"}, mem_rsp_err, exp_err);
        @(negedge clk);
        chkv({tag, " R8 idle"}, mem_rsp_valid, 0);
    endtask

    // Measures the wait after a config write; called right after wr() returns
    task automatic measure_wait(input int ival);
        int k;
        int bad;
        int expw;
        expw = (ival << SH) > 0 ? (ival << SH) : 1;
        k = 0; bad = 0;
        while (!dram_cke && k < expw + 10) begin
            if (!dram_reset_n || init_done) bad++;
            @(negedge clk);
            k++;
        end
        chkv($sformatf("R4 wait length I=%0d", ival), k, expw);
        chkv($sformatf("R4 reset high during wait I=%0d", ival), bad, 0);
        step(1);
        chkv("R6 command pulse", init_cmd_pulse, 1);
        chkv("R6 done not yet", init_done, 0);
        step(1);
        chkv("R6 pulse single", init_cmd_pulse, 0);
        chkv("R6 done", init_done, 1);
    endtask

    task automatic check_refresh(input int ival, input bit period_too);
        int m;
        int p;
        if (ival == 0) begin
            m = 0;
            for (int i = 0; i < 40; i++) begin
                if (refresh_pulse) m++;
                @(negedge clk);
            end
            chkv("R9 zero interval no strobe", m, 0);
        end else begin
            m = 0;
            while (!refresh_pulse && m < ival + 5) begin
                @(negedge clk);
                m++;
            end
            chkv($sformatf("R9 first strobe I=%0d", ival), m, ival - 1);
            if (period_too) begin
                @(negedge clk);
                p = 1;
                while (!refresh_pulse && p < ival + 5) begin
                    @(negedge clk);
                    p++;
                end
                chkv($sformatf("R9 period I=%0d", ival), p, ival);
            end
        end
    endtask

    task automatic run_seq(input int ival);
        wr(2'd0, 32'(ival));
        wr(2'd1, 32'hC0DE_0000 | 32'(ival));
        measure_wait(ival);
        check_refresh(ival, ival <= 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int ivals[8] = '{0, 1, 2, 3, 5, 7, 16, 33};

        step(3);
        rst_n = 1'b1;
        step(2);
        // R1
        chkv("R1 reset_n low", dram_reset_n, 0);
        chkv("R1 cke low", dram_cke, 0);
        chkv("R1 done low", init_done, 0);
        chkv("R1 no pulse", init_cmd_pulse, 0);
        chkv("R1 no refresh", refresh_pulse, 0);
        rd(2'd3, d); chkv("R10 status idle", d, 0);

        // R2 register map
        wr(2'd0, 32'hFFFF_0007);
        rd(2'd0, d); chkv("R2 interval field", d, 32'h0000_0007);
        wr(2'd2, 32'hFFFF_FFFE);
        rd(2'd2, d); chkv("R2 permit bit0 only", d, 0);
        wr(2'd2, 32'h1);
        rd(2'd2, d); chkv("R2 permit set", d, 1);
        rd(2'd1, d); chkv("R2 config reset value", d, 0);

        // R3 other writes do not start
        step(5);
        chkv("R3 no start from other writes", dram_reset_n, 0);
        mem_probe("idle");

        // R5 permit gate
        wr(2'd2, 32'h0);
        wr(2'd0, 32'd2);
        wr(2'd1, 32'hA5A5_0001);
        chkv("R3 reset high after start", dram_reset_n, 1);
        chkv("R3 cke low after start", dram_cke, 0);
        rd(2'd1, d); chkv("R2 config readback", d, 32'hA5A5_0001);
        rd(2'd3, d); chkv("R10 busy during wait", d, 1);
        mem_probe("busy");
        step(20);
        chkv("R5 cke held low", dram_cke, 0);
        chkv("R5 done held low", init_done, 0);
        chkv("R9 no refresh before done", refresh_pulse, 0);
        rd(2'd3, d); chkv("R10 busy while held", d, 1);
        wr(2'd2, 32'h1);
        chkv("R5 cke low at permit edge", dram_cke, 0);
        step(1);
        chkv("R5 cke rises after permit", dram_cke, 1);
        step(1);
        chkv("R6 pulse after gated rise", init_cmd_pulse, 1);
        step(1);
        chkv("R6 done after gated rise", init_done, 1);
        rd(2'd3, d); chkv("R10 status ready", d, 2);
        mem_probe("ready");
        wr(2'd2, 32'h0);
        chkv("R5 cke drops on permit clear", dram_cke, 0);
        chkv("R6 done stays", init_done, 1);
        wr(2'd2, 32'h1);
        chkv("R5 cke returns", dram_cke, 1);

        // R4/R6/R9 sweep
        foreach (ivals[i]) run_seq(ivals[i]);

        // R7 restart with interval current at restart
        wr(2'd0, 32'd4);
        wr(2'd1, 32'h1111_0004);
        step(5);
        wr(2'd0, 32'd9);
        step(3);
        chkv("R7 interval write does not end wait early", dram_cke, 0);
        wr(2'd0, 32'd2);
        wr(2'd1, 32'h2222_0002);
        measure_wait(2);

        // R7 config write after done clears done
        wr(2'd1, 32'h3333_0002);
        chkv("R7 done cleared", init_done, 0);
        chkv("R7 reset stays high", dram_reset_n, 1);
        chkv("R7 cke low on restart", dram_cke, 0);
        rd(2'd3, d); chkv("R10 busy on restart", d, 1);
        measure_wait(2);

        // R9 interval rewrite reloads the refresh count
        wr(2'd0, 32'd5);
        check_refresh(5, 1'b1);
        wr(2'd0, 32'd0);
        check_refresh(0, 1'b0);

        // R4 full-size interval value, scaled by WAIT_SHIFT
        run_seq(32'h3100);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule